// File: doc/BRIEF.md
# Lockable Victim Way Selector

This block picks which way of a 64-way set-associative cache is evicted when the miss logic needs to fill a line. It offers two replacement policies, pseudo-random and round-robin, and the operating system can switch between them at any time. A lock-down floor keeps every way below a programmable base out of reach of eviction. Critical code or data placed in those low ways therefore stays resident.

The miss logic raises a request together with the miss address. One cycle later the block returns the chosen way with a one-cycle valid strobe. It also returns the set index taken from the address, as a convenience for the fill logic. The default geometry is 32 KB with 32-byte lines across 64 ways, which gives 16 sets. Address bits [8:5] select the set and bits [4:0] lie inside the line.

Top module: `victim_way_sel`

## Requirements
- R1: While `rstN` is low, `rspValid` is 0 and `reqReady` is 1. Reset leaves the configuration at pseudo-random policy with lock base 0, the round-robin pointer at way 0, and the random state at 6'h01.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both 1. `rspValid` is high for exactly the one cycle after acceptance, and `reqReady` is 0 during that cycle. A request held high through that cycle is accepted on the following edge.
- R3: `rspSet` equals bits [8:5] of the `reqAddr` that was accepted.
- R4: A returned way is never below the lock base that was in force when the request was accepted, in either policy.
- R5: In round-robin mode, successive grants return consecutive ways. After way 63 the next grant returns the lock base, not way 0.
- R6: If the lock base is raised above the round-robin pointer, the pointer moves to the lock base. The next round-robin grant then returns the lock base.
- R7: The random state is a 6-bit shift register that steps on every clock. Each step computes next = {s[4:0], s[5]^s[4]}, starting from 6'h01 at reset. In random mode, a state value at or above the lock base L is returned as it stands.
- R8: In random mode, a state value s below L is folded to L + (s & M). M is one less than the largest power of two not exceeding 64-L. With L = 63 the result is always 63.
- R9: `cfgPolicy` = 1 selects round-robin and 0 selects random. Policy and lock base are captured on an edge where `cfgWrEn` is 1. A request accepted on that same edge still uses the previous configuration.
- R10: Grants made in random mode leave the round-robin pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgPolicy | input | 1 | Policy to load: 1 round-robin, 0 random |
| cfgLockBase | input | 6 | Lock base to load; ways below it are protected |
| reqValid | input | 1 | Victim request from miss logic |
| reqAddr | input | 32 | Miss address |
| reqReady | output | 1 | Request can be accepted this cycle |
| rspValid | output | 1 | One-cycle strobe: victim result valid |
| rspWay | output | 6 | Chosen victim way |
| rspSet | output | 4 | Set index of the accepted request |

## Verification
A configuration write and a request can land on the same clock edge. When they do, the request must still be served with the old policy and lock base, and the new values apply only from the next acceptance. The bench provokes this directly by raising `cfgWrEn` and `reqValid` together while round-robin is active and switching to random with a lower lock base. It expects the old round-robin way to be returned. The random phase then mixes writes and requests freely, and a bench model that applies configuration after serving the edge's request judges every response.

// File: rtl/vws_pkg.sv
package vws_pkg;

  typedef enum logic {
    POL_RANDOM = 1'b0,
    POL_ROBIN  = 1'b1
  } policy_e;

  // strobes from control to datapath, all valid for one edge
  typedef struct packed {
    logic accept;   // request taken on this edge
    logic cfgLoad;  // configuration captured on this edge
    logic rrStep;   // round-robin pointer advances on this edge
  } vwsStrobes_t;

endpackage

// File: rtl/vws_ctrl.sv
module vws_ctrl
  import vws_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        cfgWrEn,
  input  logic        policyIsRobin,
  output vwsStrobes_t strb,
  output logic        reqReady,
  output logic        rspValid
);

  logic respPending;

  assign reqReady = ~respPending;
  assign rspValid = respPending;

  always_comb begin
    strb.accept  = reqValid & ~respPending;
    strb.cfgLoad = cfgWrEn;
    strb.rrStep  = reqValid & ~respPending & policyIsRobin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respPending <= 1'b0;
    end else begin
      respPending <= strb.accept;
    end
  end

  // R2
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  // R2
  rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2
  ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

endmodule

// File: rtl/vws_datapath.sv
module vws_datapath
  import vws_pkg::*;
#(
  parameter int WAY_W   = 6,
  parameter int ADDR_W  = 32,
  parameter int SET_W   = 4,
  parameter int SET_LSB = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  vwsStrobes_t       strb,
  input  logic              cfgPolicy,
  input  logic [WAY_W-1:0]  cfgLockBase,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              policyIsRobin,
  output logic [WAY_W-1:0]  rspWay,
  output logic [SET_W-1:0]  rspSet
);

  localparam int WAYS = 1 << WAY_W;
  localparam logic [WAY_W-1:0] TOP_WAY = WAY_W'(WAYS - 1);
  localparam logic [WAY_W-1:0] LFSR_SEED = WAY_W'(1);

  policy_e          policyReg;
  logic [WAY_W-1:0] lockReg;
  logic [WAY_W-1:0] rrPtr;
  logic [WAY_W-1:0] lfsr;
  logic [WAY_W-1:0] wayReg;
  logic [SET_W-1:0] setReg;

  logic [WAY_W-1:0] ptrEff;
  logic [WAY_W-1:0] ptrAdv;
  logic [WAY_W-1:0] ptrNext;
  logic [WAY_W:0]   freeSpan;
  logic [WAY_W-1:0] foldMask;
  logic [WAY_W-1:0] rndWay;
  logic [WAY_W-1:0] victimNext;
  logic [WAY_W-1:0] lfsrNext;

  assign policyIsRobin = (policyReg == POL_ROBIN);
  assign rspWay = wayReg;
  assign rspSet = setReg;

  // mask of the largest power of two that fits the unlocked span
  function automatic logic [WAY_W-1:0] spanMask(input logic [WAY_W:0] span);
    logic [WAY_W-1:0] m;
    m = '0;
    for (int i = 0; i <= WAY_W; i++) begin
      if (span[i]) m = WAY_W'((1 << i) - 1);
    end
    return m;
  endfunction

  // round-robin pointer: lifted to the floor, then stepped with wrap to it
  always_comb begin
    ptrEff  = (rrPtr < lockReg) ? lockReg : rrPtr;
    ptrAdv  = (ptrEff == TOP_WAY) ? lockReg : ptrEff + 1'b1;
    ptrNext = strb.rrStep ? ptrAdv : ptrEff;
  end

  // random pick folded into the unlocked range
  always_comb begin
    freeSpan = (WAY_W + 1)'(WAYS) - {1'b0, lockReg};
    foldMask = spanMask(freeSpan);
    rndWay   = (lfsr >= lockReg) ? lfsr : lockReg + (lfsr & foldMask);
  end

  // feedback taps for a maximal-length sequence
  generate
    if (WAY_W == 6) begin : g_tap6
      assign lfsrNext = {lfsr[WAY_W-2:0], lfsr[5] ^ lfsr[4]};
    end else if (WAY_W == 5) begin : g_tap5
      assign lfsrNext = {lfsr[WAY_W-2:0], lfsr[4] ^ lfsr[2]};
    end else if (WAY_W == 4) begin : g_tap4
      assign lfsrNext = {lfsr[WAY_W-2:0], lfsr[3] ^ lfsr[2]};
    end else begin : g_tapDefault
      assign lfsrNext = {lfsr[WAY_W-2:0], lfsr[WAY_W-1] ^ lfsr[0]};
    end
  endgenerate

  assign victimNext = policyIsRobin ? ptrEff : rndWay;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      policyReg <= POL_RANDOM;
      lockReg   <= '0;
      rrPtr     <= '0;
      lfsr      <= LFSR_SEED;
      wayReg    <= '0;
      setReg    <= '0;
    end else begin
      lfsr  <= lfsrNext;
      rrPtr <= ptrNext;
      if (strb.accept) begin
        wayReg <= victimNext;
        setReg <= reqAddr[SET_LSB +: SET_W];
      end
      if (strb.cfgLoad) begin
        policyReg <= policy_e'(cfgPolicy);
        lockReg   <= cfgLockBase;
      end
    end
  end

  // R4
  victim_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.accept) |-> (wayReg >= $past(lockReg)));

  // R6
  ptr_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    rrPtr >= $past(lockReg));

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != '0);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.rrStep) && ($past(rrPtr) >= $past(lockReg)) && ($past(rrPtr) != TOP_WAY))
      |-> (rrPtr == WAY_W'($past(rrPtr) + 1'b1)));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.accept) && !$past(policyIsRobin) && ($past(rrPtr) >= $past(lockReg)))
      |-> $stable(rrPtr));

endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel
  import vws_pkg::*;
#(
  parameter int WAY_W   = 6,
  parameter int ADDR_W  = 32,
  parameter int SET_W   = 4,
  parameter int SET_LSB = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgPolicy,
  input  logic [WAY_W-1:0]  cfgLockBase,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              reqReady,
  output logic              rspValid,
  output logic [WAY_W-1:0]  rspWay,
  output logic [SET_W-1:0]  rspSet
);

  vwsStrobes_t strb;
  logic        policyIsRobin;

  vws_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .cfgWrEn       (cfgWrEn),
    .policyIsRobin (policyIsRobin),
    .strb          (strb),
    .reqReady      (reqReady),
    .rspValid      (rspValid)
  );

  vws_datapath #(
    .WAY_W   (WAY_W),
    .ADDR_W  (ADDR_W),
    .SET_W   (SET_W),
    .SET_LSB (SET_LSB)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .cfgPolicy     (cfgPolicy),
    .cfgLockBase   (cfgLockBase),
    .reqAddr       (reqAddr),
    .policyIsRobin (policyIsRobin),
    .rspWay        (rspWay),
    .rspSet        (rspSet)
  );

endmodule

// File: tb/victim_way_sel_tb_top.sv
module victim_way_sel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgPolicy = 1'b0;
  logic [5:0]  cfgLockBase = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqReady;
  logic        rspValid;
  logic [5:0]  rspWay;
  logic [3:0]  rspSet;

  always #5 clk = ~clk;

  victim_way_sel dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgPolicy(cfgPolicy),
    .cfgLockBase(cfgLockBase), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqReady(reqReady), .rspValid(rspValid), .rspWay(rspWay), .rspSet(rspSet)
  );

  int nChecks = 0;
  int nFail = 0;
  bit running = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // largest power of two not above span, minus one
  function automatic int foldM(input int span);
    int m = 0;
    for (int i = 0; i <= 6; i++) if (span >= (1 << i)) m = (1 << i) - 1;
    return m;
  endfunction

  function automatic int rndPick(input int s, input int l);
    return (s >= l) ? s : l + (s & foldM(64 - l));
  endfunction

  // reference model built from the requirements
  int mPolicy, mLock, mPtr, mLfsr, mExpWay, mExpSet, mAccLock;
  bit mExpValid;

  always @(posedge clk) begin
    if (!rstN) begin
      mPolicy = 0; mLock = 0; mPtr = 0; mLfsr = 1; mExpValid = 0;
    end else begin
      int eff;
      bit acc;
      acc = reqValid && !mExpValid;
      eff = (mPtr < mLock) ? mLock : mPtr;
      if (acc) begin
        mAccLock = mLock;
        mExpSet = (reqAddr >> 5) & 15;
        if (mPolicy == 1) begin
          mExpWay = eff;
          mPtr = (eff == 63) ? mLock : eff + 1;
        end else begin
          mExpWay = rndPick(mLfsr, mLock);
          mPtr = eff;
        end
      end else begin
        mPtr = eff;
      end
      mExpValid = acc;
      mLfsr = ((mLfsr << 1) & 63) | (((mLfsr >> 5) ^ (mLfsr >> 4)) & 1);
      if (cfgWrEn) begin
        mPolicy = cfgPolicy;
        mLock = cfgLockBase;
      end
    end
  end

  // continuous comparison against the model
  always @(negedge clk) begin
    if (running && rstN) begin
      chk(rspValid == mExpValid, "R2 strobe", rspValid, mExpValid);
      chk(reqReady == !rspValid, "R2 ready", reqReady, !rspValid);
      if (rspValid && mExpValid) begin
        chk(rspWay == mExpWay, "R5/R7 way", rspWay, mExpWay);
        chk(rspSet == mExpSet, "R3 set", rspSet, mExpSet);
        chk(rspWay >= mAccLock, "R4 floor", rspWay, mAccLock);
      end
    end
  end

  task automatic cfgWrite(input bit pol, input int lk);
    cfgWrEn = 1'b1; cfgPolicy = pol; cfgLockBase = 6'(lk);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // one request; exp < 0 leaves the way to the model comparison
  task automatic reqOne(input int addr, input int exp, input string tag);
    reqValid = 1'b1; reqAddr = 32'(addr);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid == 1'b1, tag, rspValid, 1);
    if (exp >= 0) chk(rspWay == exp, tag, rspWay, exp);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 outputs in reset
    chk(rspValid == 1'b0, "R1 rspValid", rspValid, 0);
    chk(reqReady == 1'b1, "R1 reqReady", reqReady, 1);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // R1 pointer starts at 0; R5 consecutive grants; R9 policy bit 1
    cfgWrite(1'b1, 0);
    reqOne(32'h0000_01E0, 0, "R1 first rr way");
    chk(rspSet == 4'hF, "R3 set bits", rspSet, 15);
    reqOne(32'h0000_0020, 1, "R5 step");
    reqOne(32'h0000_0040, 2, "R5 step");

    // R6 lock above pointer
    cfgWrite(1'b1, 40);
    @(negedge clk);
    reqOne(32'h100, 40, "R6 lifted");

    // R10 random grants leave pointer alone
    cfgWrite(1'b0, 40);
    reqOne(32'h200, -1, "R7 random");
    reqOne(32'h300, -1, "R7 random");
    cfgWrite(1'b1, 40);
    reqOne(32'h400, 41, "R10 pointer held");

    // R5 wrap to lock base
    cfgWrite(1'b1, 61);
    reqOne(32'h0, 61, "R6 lifted");
    reqOne(32'h0, 62, "R5 step");
    reqOne(32'h0, 63, "R5 top");
    reqOne(32'h0, 61, "R5 wrap to base");

    // R9 config write and request on the same edge
    cfgWrEn = 1'b1; cfgPolicy = 1'b0; cfgLockBase = 6'd0;
    reqValid = 1'b1; reqAddr = 32'h60;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    chk(rspWay == 62, "R9 old config used", rspWay, 62);
    @(negedge clk);
    reqOne(32'h80, -1, "R9 new policy random");

    cfgWrite(1'b1, 0);
    reqOne(32'h0, 63, "R5 top lock0");
    reqOne(32'h0, 0, "R5 wrap to 0");

    // R8 fully locked but one way
    cfgWrite(1'b0, 63);
    for (int i = 0; i < 5; i++) reqOne(32'h0, 63, "R8 single way");
    cfgWrite(1'b0, 48);
    for (int i = 0; i < 8; i++) reqOne(i * 32, -1, "R8 fold");

    // R2 held request: accepted every other edge
    cfgWrite(1'b1, 0);
    reqValid = 1'b1;
    @(negedge clk);
    chk(rspValid == 1'b1 && rspWay == 63, "R2 held first", rspWay, 63);
    @(negedge clk);
    chk(rspValid == 1'b0, "R2 gap", rspValid, 0);
    @(negedge clk);
    chk(rspValid == 1'b1 && rspWay == 0, "R2 held second", rspWay, 0);
    reqValid = 1'b0;
    @(negedge clk);

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      cfgWrEn = (($urandom % 8) == 0);
      cfgPolicy = $urandom % 2;
      case ($urandom % 4)
        0: cfgLockBase = 6'd0;
        1: cfgLockBase = 6'(60 + ($urandom % 4));
        default: cfgLockBase = 6'($urandom % 64);
      endcase
      reqValid = (($urandom % 3) != 0);
      reqAddr = $urandom;
      @(negedge clk);
    end
    cfgWrEn = 1'b0;
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule